// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation converter. It decides when a conversion starts and holds the analog multiplexer on the chosen channel. It opens a fixed acquisition window, then walks a trial code down from the most significant bit to the least. At each step it keeps or clears the current bit according to one comparator bit from the analog side. The finished code is written to a result register, either as an unsigned value or as a sign-extended two's complement value, depending on the input configuration in force when the conversion started.

A conversion can start in three ways. Software can issue a one-shot request, or set free-running operation. In the third way, the rising edge of one of several hardware trigger lines starts it. A trigger line that is still high when a conversion finishes starts the next one with no gap. One channel code past the external inputs selects an internal die-temperature channel. The analog front end and the comparator sit outside the block.

Top module: `adc_sar_seq`

## Requirements
- R1: During and right after a synchronous reset, busy_o, done_o, sample_o and result_o are all zero.
- R2: The trial code presented on dac_code_o is 0x800 in the first trial cycle. Each later trial cycle keeps the upper bits already decided, where cmp_i=1 keeps the bit. It sets the next lower bit, so an ideal comparator yields the target code.
- R3: Take the clock edge that accepts a start as edge 0. sample_o is high for the 2 cycles after edges 0 and 1. Trial codes follow edges 2 to 13. done_o is a single-cycle pulse after edge 15, when result_o updates. busy_o is high from edge 0 until edge 15.
- R4: With in_mode_i 0 (single-ended), 1 (pseudo-differential) or 3 (treated as single-ended), the result is the 12-bit code zero-extended into result_o.
- R5: With in_mode_i 2 (fully differential), the result is the 12-bit code with its MSB inverted, then sign-extended to the full width of result_o.
- R6: With run_mode_i 1 (single), a pulse on sw_start_i while idle starts exactly one conversion. A pulse while busy is ignored.
- R7: With run_mode_i 2 (continuous), conversions run back to back. A new acquisition begins on the same edge that raises done_o, so busy_o stays high.
- R8: Setting run_mode_i to 0 (off) lets the conversion in progress finish normally, and then no further conversion starts.
- R9: With run_mode_i 3 (hardware), a rising edge on trig_i[trig_sel_i] starts a conversion. Activity on trigger lines that are not selected has no effect.
- R10: In hardware mode, if the selected trigger is still high on the edge that writes the result, the next conversion starts on that edge. If it is low, the block goes idle.
- R11: A channel request below 16 is passed through to chan_o. Any code of 16 or more maps to the temperature code 16 and raises temp_sel_o.
- R12: The channel and input mode are latched when a conversion starts. Changes to chan_i or in_mode_i during a conversion do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode_i | input | 2 | 0 off, 1 single, 2 continuous, 3 hardware trigger |
| sw_start_i | input | 1 | One-shot start request in single mode |
| trig_i | input | 4 | Hardware trigger lines |
| trig_sel_i | input | 2 | Index of the active trigger line |
| in_mode_i | input | 2 | 0 single-ended, 1 pseudo-differential, 2 fully differential, 3 as 0 |
| chan_i | input | 5 | Requested input channel |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dac_code_o | output | 12 | Trial code to the capacitor DAC |
| sample_o | output | 1 | Track phase of the sample-and-hold |
| chan_o | output | 5 | Channel held on the multiplexer |
| temp_sel_o | output | 1 | Temperature channel selected |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse with each new result |
| result_o | output | 16 | Formatted conversion result |

## Verification
The bench drives inputs on falling edges and counts falling edges from the stimulus. Falling edge k therefore shows the state after accept edge k-1. The sample window is expected at falling edges 1 and 2, and trial code n at falling edge 3+n. busy_o is expected high through falling edge 15, with done_o and the new result at falling edge 16. For back-to-back runs, the results are due at falling edges 16, 31 and 46. After each run stops, a fixed idle window confirms that no stray start occurred.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    RUN_OFF    = 2'd0,
    RUN_SINGLE = 2'd1,
    RUN_CONT   = 2'd2,
    RUN_HW     = 2'd3
  } run_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_TRIAL,
    ST_FMT
  } seq_state_e;

  localparam logic [1:0] IN_DIFF = 2'd2;

endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
  parameter int N_SRC = 4,
  parameter int SEL_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] trig_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             level_o,
  output logic             rise_o
);

  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] rise_vec;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= trig_i;
  end

  // one edge detector per source, so switching the select never fakes an edge
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign rise_vec[g] = trig_i[g] & ~prev_q[g];
  end

  assign level_o = trig_i[sel_i];
  assign rise_o  = rise_vec[sel_i];

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic         last_o
);

  localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q;
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      code_q <= MSB_ONE;
      mask_q <= MSB_ONE;
    end else if (step_i) begin
      code_q <= (cmp_i ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
  end

  assign code_o = code_q;
  assign last_o = mask_q[0];

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int W     = 12,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             signed_i,
  input  logic [W-1:0]     code_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);

  localparam int EXT_W = RES_W - W;
  localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]     twos;
  logic [RES_W-1:0] fmt;
  logic [RES_W-1:0] res_q;
  logic             done_q;

  // offset binary to two's complement: flip the top bit
  assign twos = code_i ^ MSB_ONE;

  always_comb begin
    if (signed_i) fmt = {{EXT_W{twos[W-1]}}, twos};
    else          fmt = {{EXT_W{1'b0}}, code_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wr_i;
      if (wr_i) res_q <= fmt;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int RES_W   = 16,
  parameter int N_EXT   = 16,
  parameter int N_TRIG  = 4,
  parameter int ACQ_CYC = 2,
  localparam int CH_W   = $clog2(N_EXT + 1),
  localparam int TSEL_W = $clog2(N_TRIG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        run_mode_i,
  input  logic              sw_start_i,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [TSEL_W-1:0] trig_sel_i,
  input  logic [1:0]        in_mode_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              sample_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              temp_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o
);

  localparam int ACQ_W = $clog2(ACQ_CYC + 1);
  localparam logic [ACQ_W-1:0] ACQ_LAST = ACQ_W'(ACQ_CYC - 1);
  localparam logic [CH_W-1:0]  TEMP_CH  = CH_W'(N_EXT);

  seq_state_e       state_q;
  logic [ACQ_W-1:0] acq_cnt_q;
  logic             fd_q;
  logic [CH_W-1:0]  chan_q;
  run_mode_e        run_mode;
  logic             trig_level, trig_rise;
  logic             start_req, again_req, launch;
  logic             sar_load, sar_step, sar_last;
  logic [CH_W-1:0]  chan_map;

  assign run_mode = run_mode_e'(run_mode_i);

  adc_trig_detect #(.N_SRC(N_TRIG), .SEL_W(TSEL_W)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig_i),
    .sel_i   (trig_sel_i),
    .level_o (trig_level),
    .rise_o  (trig_rise)
  );

  // request from idle
  always_comb begin
    unique case (run_mode)
      RUN_SINGLE: start_req = sw_start_i;
      RUN_CONT:   start_req = 1'b1;
      RUN_HW:     start_req = trig_rise;
      default:    start_req = 1'b0;
    endcase
  end

  // request on the result-write edge: no fresh edge needed
  always_comb begin
    unique case (run_mode)
      RUN_CONT: again_req = 1'b1;
      RUN_HW:   again_req = trig_level;
      default:  again_req = 1'b0;
    endcase
  end

  assign launch   = ((state_q == ST_IDLE) && start_req) ||
                    ((state_q == ST_FMT) && again_req);
  assign chan_map = (chan_i >= TEMP_CH) ? TEMP_CH : chan_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      acq_cnt_q <= '0;
      fd_q      <= 1'b0;
      chan_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            state_q   <= ST_ACQ;
            acq_cnt_q <= '0;
          end
        end
        ST_ACQ: begin
          if (acq_cnt_q == ACQ_LAST) state_q <= ST_TRIAL;
          else acq_cnt_q <= acq_cnt_q + 1'b1;
        end
        ST_TRIAL: begin
          if (sar_last) state_q <= ST_FMT;
        end
        ST_FMT: begin
          if (again_req) begin
            state_q   <= ST_ACQ;
            acq_cnt_q <= '0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (launch) begin
        fd_q   <= (in_mode_i == IN_DIFF);
        chan_q <= chan_map;
      end
    end
  end

  assign sar_load = (state_q == ST_ACQ) && (acq_cnt_q == ACQ_LAST);
  assign sar_step = (state_q == ST_TRIAL);

  adc_sar_reg #(.W(DATA_W)) u_sar (
    .clk    (clk),
    .rst    (rst),
    .load_i (sar_load),
    .step_i (sar_step),
    .cmp_i  (cmp_i),
    .code_o (dac_code_o),
    .last_o (sar_last)
  );

  adc_result_fmt #(.W(DATA_W), .RES_W(RES_W)) u_fmt (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (state_q == ST_FMT),
    .signed_i (fd_q),
    .code_i   (dac_code_o),
    .result_o (result_o),
    .done_o   (done_o)
  );

  assign sample_o   = (state_q == ST_ACQ);
  assign busy_o     = (state_q != ST_IDLE);
  assign chan_o     = chan_q;
  assign temp_sel_o = (chan_q == TEMP_CH);

endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int DATA_W  = 12,
  parameter int RES_W   = 16,
  parameter int ACQ_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        run_mode,
  input logic              busy,
  input logic              done,
  input logic              sample,
  input logic              fd,
  input logic [DATA_W-1:0] dac_code,
  input logic [RES_W-1:0]  result
);

  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  int unsigned samp_cnt;

  always_ff @(posedge clk) begin
    if (rst)         samp_cnt <= 0;
    else if (sample) samp_cnt <= samp_cnt + 1;
    else             samp_cnt <= 0;
  end

  a_r3_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  a_r3_acq_window: assert property (@(posedge clk) disable iff (rst)
    $fell(sample) |-> (samp_cnt == ACQ_CYC) && busy);

  a_r2_first_trial_msb: assert property (@(posedge clk) disable iff (rst)
    $fell(sample) |-> dac_code == MSB_ONE);

  a_r4_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (done && !fd) |-> result[RES_W-1:DATA_W] == '0);

  a_r5_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (done && fd) |-> ($countones(result[RES_W-1:DATA_W-1]) == 0 ||
                      $countones(result[RES_W-1:DATA_W-1]) == RES_W - DATA_W + 1));

  a_r8_off_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && run_mode == 2'd0) |=> !busy);

endmodule

bind adc_sar_seq adc_sar_seq_chk #(
  .DATA_W(DATA_W), .RES_W(RES_W), .ACQ_CYC(ACQ_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run_mode (run_mode_i),
  .busy     (busy_o),
  .done     (done_o),
  .sample   (sample_o),
  .fd       (fd_q),
  .dac_code (dac_code_o),
  .result   (result_o)
);

// File: tb/adc_sar_seq_test.sv
module adc_sar_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  run_mode_i = 2'd0;
  logic        sw_start_i = 1'b0;
  logic [3:0]  trig_i = 4'd0;
  logic [1:0]  trig_sel_i = 2'd0;
  logic [1:0]  in_mode_i = 2'd0;
  logic [4:0]  chan_i = 5'd0;
  logic        cmp_i;
  logic [11:0] dac_code_o;
  logic        sample_o, temp_sel_o, busy_o, done_o;
  logic [4:0]  chan_o;
  logic [15:0] result_o;
  logic [11:0] target = 12'd0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  // ideal analog side: input at or above the trial code keeps the bit
  assign cmp_i = (target >= dac_code_o);

  adc_sar_seq uut (
    .clk(clk), .rst(rst), .run_mode_i(run_mode_i), .sw_start_i(sw_start_i),
    .trig_i(trig_i), .trig_sel_i(trig_sel_i), .in_mode_i(in_mode_i),
    .chan_i(chan_i), .cmp_i(cmp_i), .dac_code_o(dac_code_o),
    .sample_o(sample_o), .chan_o(chan_o), .temp_sel_o(temp_sel_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic logic [11:0] trial_code(input logic [11:0] tgt, input int bitpos);
    int t;
    t = ((int'(tgt) >> (bitpos + 1)) << (bitpos + 1)) | (1 << bitpos);
    return t[11:0];
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "sample", sample_o, 0);
    chk("R1", "result", result_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", busy_o, 0);
  endtask

  // one software-started conversion, full cycle-by-cycle check
  task automatic t_single(input logic [1:0] mode, input logic [11:0] tgt,
                          input logic [15:0] exp_res, input logic [4:0] ch,
                          input logic [4:0] exp_ch, input logic exp_temp,
                          input bit disturb);
    int bad_busy = 0, bad_samp = 0, bad_dac = 0, bad_done = 0, stray = 0;
    @(negedge clk);
    run_mode_i = 2'd1; in_mode_i = mode; chan_i = ch; target = tgt;
    sw_start_i = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 1) begin
        sw_start_i = 1'b0;
        chk("R11", "chan_o", chan_o, exp_ch);
        chk("R11", "temp_sel_o", temp_sel_o, exp_temp);
      end
      if (disturb && k == 5) begin
        sw_start_i = 1'b1;
        chan_i = 5'd1;
        in_mode_i = 2'd0;
      end
      if (disturb && k == 6) sw_start_i = 1'b0;
      if (disturb && k == 10) chk("R12", "chan_o held", chan_o, exp_ch);
      if (busy_o !== (k <= 15)) bad_busy++;
      if (sample_o !== (k <= 2)) bad_samp++;
      if (done_o !== (k == 16)) bad_done++;
      if (k >= 3 && k <= 14 && dac_code_o !== trial_code(tgt, 14 - k)) bad_dac++;
    end
    chk("R3", "busy window errors", bad_busy, 0);
    chk("R3", "sample window errors", bad_samp, 0);
    chk("R3", "done timing errors", bad_done, 0);
    chk("R2", "trial sequence errors", bad_dac, 0);
    chk(mode == 2'd2 ? "R5" : "R4", "result", result_o, exp_res);
    if (disturb) begin
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (busy_o || done_o) stray++;
      end
      chk("R6", "start while busy ignored", stray, 0);
    end
    run_mode_i = 2'd0;
    @(negedge clk);
  endtask

  task automatic t_continuous();
    int stray = 0;
    @(negedge clk);
    in_mode_i = 2'd0; chan_i = 5'd2; target = 12'h6B3;
    run_mode_i = 2'd2;
    for (int k = 1; k <= 31; k++) begin
      @(negedge clk);
      if (k == 16) begin
        chk("R7", "done 1", done_o, 1);
        chk("R7", "busy held", busy_o, 1);
        chk("R7", "restart sample", sample_o, 1);
        chk("R7", "result 1", result_o, 16'h06B3);
        target = 12'h1E0;
      end
      if (k == 17) chk("R7", "second acq cycle", sample_o, 1);
      if (k == 18) chk("R7", "second acq ends", sample_o, 0);
      if (k == 20) run_mode_i = 2'd0;
      if (k == 25) chk("R8", "not truncated", busy_o, 1);
      if (k == 31) begin
        chk("R8", "done 2", done_o, 1);
        chk("R8", "busy dropped", busy_o, 0);
        chk("R8", "result 2", result_o, 16'h01E0);
      end
    end
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy_o || done_o) stray++;
    end
    chk("R8", "stays stopped", stray, 0);
  endtask

  task automatic t_hw();
    int stray = 0;
    @(negedge clk);
    run_mode_i = 2'd3; trig_sel_i = 2'd2; in_mode_i = 2'd1;
    chan_i = 5'd7; target = 12'h3C1;
    trig_i = 4'b1001;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (busy_o) stray++;
    end
    trig_i = 4'b0000;
    @(negedge clk);
    chk("R9", "unselected lines ignored", stray, 0);
    trig_i[2] = 1'b1;
    for (int k = 1; k <= 46; k++) begin
      @(negedge clk);
      if (k == 1) chk("R9", "selected edge starts", busy_o, 1);
      if (k == 16) begin
        chk("R10", "done 1", done_o, 1);
        chk("R10", "restart busy", busy_o, 1);
        chk("R4", "pseudo-diff result", result_o, 16'h03C1);
      end
      if (k == 31) begin
        chk("R10", "done 2", done_o, 1);
        chk("R10", "restart 2 busy", busy_o, 1);
      end
      if (k == 35) trig_i[2] = 1'b0;
      if (k == 46) begin
        chk("R10", "done 3", done_o, 1);
        chk("R10", "stops when low", busy_o, 0);
      end
    end
    stray = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy_o) stray++;
    end
    chk("R10", "idle after trigger low", stray, 0);
    run_mode_i = 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_single(2'd0, 12'hA5C, 16'h0A5C, 5'd3,  5'd3,  1'b0, 1'b0);
    t_single(2'd0, 12'hFFF, 16'h0FFF, 5'd16, 5'd16, 1'b1, 1'b0);
    t_single(2'd0, 12'h000, 16'h0000, 5'd25, 5'd16, 1'b1, 1'b0);
    t_single(2'd1, 12'h123, 16'h0123, 5'd15, 5'd15, 1'b0, 1'b0);
    t_single(2'd2, 12'd2047, 16'hFFFF, 5'd9,  5'd9,  1'b0, 1'b1);
    t_single(2'd2, 12'd0,    16'hF800, 5'd4,  5'd4,  1'b0, 1'b0);
    t_single(2'd2, 12'd4095, 16'h07FF, 5'd4,  5'd4,  1'b0, 1'b0);
    t_single(2'd2, 12'd2048, 16'h0000, 5'd4,  5'd4,  1'b0, 1'b0);
    t_single(2'd3, 12'h800, 16'h0800, 5'd0,  5'd0,  1'b0, 1'b0);
    t_continuous();
    t_hw();
    summary();
    $finish;
  end

endmodule